// File: doc/BRIEF.md
# Dual-I/O Flash Read Responder

This block is the device side of a serial flash read port in two-wire mode. The host lowers chip select and clocks in an 8-bit command, then a 24-bit address. Every bit moves in pairs on data lines 1 and 0. After a wait of some dummy clocks the block drives read data back two bits per clock on the same lines. It keeps doing so, with a rising byte address, until chip select goes high. Two kinds of read are served. The first is a fast read of a 256-byte array, which three different command codes select. The second is a read of a 64-byte one-time-programmable (OTP) area.

The block runs on a fast system clock and oversamples the serial pins through synchronizers. It samples input pairs on rising serial-clock edges and changes output pairs on falling edges. The fast-read wait length comes from a small configuration register that a host-side write strobe loads. The OTP wait is fixed. A separate output enable tells the pad ring when the block owns the data lines.

Top module: `dual_io_flash_rd`

## Requirements
- R1: The command byte is taken over 4 rising serial clocks, most significant pair first. Each clock carries the odd-numbered bit on `dq_i[1]` and the even-numbered bit on `dq_i[0]`.
- R2: Commands 8'h0B, 8'h3B and 8'hBB all start the same fast read of the main array.
- R3: The address takes 12 rising clocks, two bits per clock, A23/A22 first. A23 and every bit above the array width are ignored. The array holds 256 bytes, and the byte at index i is (3*i + 8'h11) mod 256.
- R4: The fast-read dummy count is a register that resets to 8 and is loaded from `dummy_val` (0 to 15) in any system cycle with `dummy_we` high. A fast read waits that many rising clocks after the address.
- R5: Data is driven on falling serial clocks, two bits per clock, MSB pair first, with the higher bit on `dq_o[1]`. Each byte takes 4 clocks. The address then increments, wrapping within the array, for as long as chip select stays low.
- R6: Command 8'h4B reads the OTP area. Only address bits [5:0] are used, the byte at index i is {2'b11, i}, and the index wraps within 64 bytes during a burst.
- R7: An OTP read always waits 8 dummy clocks, whatever the configuration register holds.
- R8: `dq_oe` is low during the command, address and dummy phases. It rises on the first data-phase falling clock and drops in the same instant that `cs_n` goes high.
- R9: Raising `cs_n` at any point aborts the transfer. The next selection starts again at the command byte.
- R10: Any other command code leaves the data lines undriven until `cs_n` goes high.
- R11: After reset, `dq_oe` is low and the dummy register holds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host, idle low |
| dq_i | input | 2 | Data lines as seen at the pads |
| dq_o | output | 2 | Data the block drives onto the lines |
| dq_oe | output | 1 | High while the block drives the data lines |
| dummy_we | input | 1 | Load strobe for the fast-read dummy count |
| dummy_val | input | 4 | New fast-read dummy count |

## Verification
A rising or falling serial-clock edge at the pins reaches the sequencer about three system cycles later. A new output pair therefore appears four system cycles after a falling pin edge. The bench holds each serial half period for six system cycles and reads `dq_o` and `dq_oe` at the very end of the low half, just before the next rising edge, so every pair it samples has settled. Release of `dq_oe` on deselect has no register in its path. The bench checks it one time unit after raising `cs_n`, and waits out the synchronizer delay before it selects the block again.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_FAST_A = 8'h0B;
  localparam logic [7:0] OP_FAST_B = 8'h3B;
  localparam logic [7:0] OP_FAST_C = 8'hBB;
  localparam logic [7:0] OP_OTP    = 8'h4B;

  // R2: three codes, one behaviour
  function automatic logic is_fast(input logic [7:0] op);
    return (op == OP_FAST_A) || (op == OP_FAST_B) || (op == OP_FAST_C);
  endfunction

endpackage

// File: rtl/dfr_pin_sync.sv
module dfr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [1:0] dq_i,
  output logic       rst_q_n,
  output logic       cs_q,
  output logic       rise,
  output logic       fall,
  output logic [1:0] dq_q
);

  localparam int PW = 4;

  logic [STAGES-1:0]         rst_pipe;
  logic [STAGES-1:0][PW-1:0] stg;
  logic                      sclk_d;
  logic                      sclk_s;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stg    <= {STAGES{4'b1000}};
      sclk_d <= 1'b0;
    end else begin
      stg    <= {stg[STAGES-2:0], {cs_n, sclk, dq_i}};
      sclk_d <= sclk_s;
    end
  end

  assign cs_q   = stg[STAGES-1][3];
  assign sclk_s = stg[STAGES-1][2];
  assign dq_q   = stg[STAGES-1][1:0];
  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;

endmodule

// File: rtl/dfr_store.sv
module dfr_store #(
  parameter int MEM_AW = 8
) (
  input  logic              otp,
  input  logic [MEM_AW-1:0] addr,
  output logic [7:0]        rd_byte
);

  logic [7:0] idx;

  generate
    if (MEM_AW >= 8) begin : g_wide
      assign idx = addr[7:0];
    end else begin : g_narrow
      assign idx = 8'(addr);
    end
  endgenerate

  // R3 array pattern, R6 OTP pattern
  always_comb begin
    if (otp) rd_byte = {2'b11, addr[5:0]};
    else     rd_byte = idx * 8'd3 + 8'h11;
  end

endmodule

// File: rtl/dfr_seq.sv
module dfr_seq
  import dfr_pkg::*;
#(
  parameter int MEM_AW    = 8,
  parameter int DUMMY_W   = 4,
  parameter int OTP_DUMMY = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_q,
  input  logic               rise,
  input  logic               fall,
  input  logic [1:0]         dq_q,
  input  logic [DUMMY_W-1:0] dummy_cnt,
  input  logic [7:0]         rd_byte,
  output phase_t             phase,
  output logic [MEM_AW-1:0]  rd_addr,
  output logic               rd_otp,
  output logic [1:0]         dq_o,
  output logic               oe_q
);

  localparam int CNT_W = (DUMMY_W > 4) ? DUMMY_W : 4;

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, dly;
  logic [5:0]        op_q, op_d;
  logic [7:0]        op_full;
  logic [MEM_AW-1:0] addr_q, addr_d, addr_inc;
  logic              otp_q, otp_d;
  logic [1:0]        pair_q, pair_d;
  logic [7:0]        sh_q, sh_d;
  logic              oe_d;

  assign op_full  = {op_q, dq_q};
  assign dly      = otp_q ? CNT_W'(OTP_DUMMY) : CNT_W'(dummy_cnt);
  // R6: OTP index wraps inside 64 bytes
  assign addr_inc = otp_q ? {addr_q[MEM_AW-1:6], addr_q[5:0] + 6'd1}
                          : addr_q + 1'b1;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    otp_d   = otp_q;
    pair_d  = pair_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    if (cs_q) begin
      // R9: deselect returns to the command phase
      phase_d = PH_CMD;
      cnt_d   = '0;
      pair_d  = '0;
      oe_d    = 1'b0;
    end else begin
      case (phase_q)
        PH_CMD: if (rise) begin
          op_d  = op_full[5:0];
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(3)) begin
            cnt_d = '0;
            if (is_fast(op_full)) begin
              phase_d = PH_ADDR;
              otp_d   = 1'b0;
            end else if (op_full == OP_OTP) begin
              phase_d = PH_ADDR;
              otp_d   = 1'b1;
            end else begin
              phase_d = PH_SKIP;
            end
          end
        end
        PH_ADDR: if (rise) begin
          addr_d = {addr_q[MEM_AW-3:0], dq_q};
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(11)) begin
            cnt_d   = dly;
            phase_d = (dly == '0) ? PH_DATA : PH_DUMMY;
          end
        end
        PH_DUMMY: if (rise) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) phase_d = PH_DATA;
        end
        PH_DATA: if (fall) begin
          oe_d   = 1'b1;
          pair_d = pair_q + 1'b1;
          if (pair_q == 2'd0) begin
            sh_d   = rd_byte;
            addr_d = addr_inc;
          end else begin
            sh_d = {sh_q[5:0], 2'b00};
          end
        end
        PH_SKIP: ;
        default: phase_d = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      otp_q   <= 1'b0;
      pair_q  <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
      otp_q   <= otp_d;
      pair_q  <= pair_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
    end
  end

  assign phase   = phase_q;
  assign rd_addr = addr_q;
  assign rd_otp  = otp_q;
  assign dq_o    = sh_q[7:6];

endmodule

// File: rtl/dual_io_flash_rd.sv
module dual_io_flash_rd
  import dfr_pkg::*;
#(
  parameter int MEM_AW      = 8,
  parameter int DUMMY_W     = 4,
  parameter int DUMMY_RESET = 8,
  parameter int OTP_DUMMY   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic [1:0]         dq_i,
  output logic [1:0]         dq_o,
  output logic               dq_oe,
  input  logic               dummy_we,
  input  logic [DUMMY_W-1:0] dummy_val
);

  logic               rst_q_n;
  logic               cs_q_w;
  logic               rise_w;
  logic               fall_w;
  logic [1:0]         dq_q_w;
  logic [DUMMY_W-1:0] dummy_q;
  logic [7:0]         byte_w;
  logic [MEM_AW-1:0]  addr_w;
  logic               otp_w;
  logic               oe_w;
  phase_t             phase_w;

  dfr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_i(dq_i),
    .rst_q_n(rst_q_n), .cs_q(cs_q_w), .rise(rise_w), .fall(fall_w),
    .dq_q(dq_q_w)
  );

  // R4: fast-read dummy register, R11 reset value
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      dummy_q <= DUMMY_W'(DUMMY_RESET);
    else if (dummy_we) dummy_q <= dummy_val;
  end

  dfr_seq #(.MEM_AW(MEM_AW), .DUMMY_W(DUMMY_W), .OTP_DUMMY(OTP_DUMMY)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .cs_q(cs_q_w), .rise(rise_w), .fall(fall_w),
    .dq_q(dq_q_w), .dummy_cnt(dummy_q), .rd_byte(byte_w), .phase(phase_w),
    .rd_addr(addr_w), .rd_otp(otp_w), .dq_o(dq_o), .oe_q(oe_w)
  );

  dfr_store #(.MEM_AW(MEM_AW)) u_store (
    .otp(otp_w), .addr(addr_w), .rd_byte(byte_w)
  );

  // R8: release follows the raw select pin, not the synchronized copy
  assign dq_oe = oe_w & ~cs_n;

endmodule

// File: rtl/dfr_chk.sv
module dfr_chk
  import dfr_pkg::*;
(
  input logic       clk,
  input logic       rst_q_n,
  input logic       cs_q,
  input logic       fall,
  input phase_t     phase,
  input logic [1:0] dq_o,
  input logic       dq_oe
);

  // R8
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase != PH_DATA) |-> !dq_oe);

  // R8
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(dq_oe) |-> $past(fall));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fall |=> $stable(dq_o));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cs_q |=> (phase == PH_CMD));

  // R10
  skip_stay_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (phase == PH_SKIP && !cs_q) |=> (phase == PH_SKIP));

endmodule

bind dual_io_flash_rd dfr_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .cs_q(cs_q_w), .fall(fall_w),
  .phase(phase_w), .dq_o(dq_o), .dq_oe(dq_oe)
);

// File: tb/dual_io_flash_rd_test.sv
module dual_io_flash_rd_test;

  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [1:0] dq_i = 2'b00;
  logic [1:0] dq_o;
  logic       dq_oe;
  logic       dummy_we = 1'b0;
  logic [3:0] dummy_val = 4'd0;

  int checks = 0;
  int fails = 0;
  int cur_dummy = 8;
  logic [1:0] s_dq;
  logic       s_oe;

  always #2 clk = ~clk;

  dual_io_flash_rd uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dq_i(dq_i),
    .dq_o(dq_o), .dq_oe(dq_oe), .dummy_we(dummy_we), .dummy_val(dummy_val)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit otp, input logic [23:0] a, input int b);
    logic [7:0] i;
    i = a[7:0] + 8'(b);
    if (otp) return {2'b11, i[5:0]};
    return i * 8'd3 + 8'h11;
  endfunction

  // one serial clock: drive pair, sample outputs at end of low half, rise, fall
  task automatic pulse(input logic [1:0] bits);
    dq_i = bits;
    tick(HALF);
    s_dq = dq_o;
    s_oe = dq_oe;
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic deselect(input string req);
    cs_n = 1'b1;
    #1;
    chk(dq_oe == 1'b0, req, dq_oe, 0);
    tick(HALF);
  endtask

  task automatic set_dummy(input int v);
    dummy_val = 4'(v);
    dummy_we  = 1'b1;
    tick(1);
    dummy_we  = 1'b0;
    cur_dummy = v;
  endtask

  task automatic send_head(input logic [7:0] op, input logic [23:0] a, input int addr_pairs);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < 4; i++) pulse(op[7-2*i -: 2]);
    for (int i = 0; i < addr_pairs; i++) pulse(a[23-2*i -: 2]);
  endtask

  task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int nb,
                         input int tail, input string req);
    bit otp;
    int dly;
    logic [7:0] got;
    otp = (op == 8'h4B);
    dly = otp ? 8 : cur_dummy;
    send_head(op, a, 12);
    for (int d = 0; d < dly; d++) begin
      pulse(2'b00);
      if (d == dly - 1) chk(s_oe == 1'b0, "R8 dummy phase", s_oe, 0);
    end
    for (int b = 0; b < nb; b++) begin
      got = '0;
      for (int p = 0; p < 4; p++) begin
        pulse(2'b00);
        got = {got[5:0], s_dq};
        if (!s_oe) got = 8'hxx;
      end
      chk(got === exp_byte(otp, a, b), req, got, exp_byte(otp, a, b));
    end
    for (int t = 0; t < tail; t++) pulse(2'b00);
    deselect("R8 R9 release on deselect");
  endtask

  task automatic bad_op(input logic [7:0] op);
    bit seen;
    seen = 1'b0;
    send_head(op, 24'hFFFFFF, 0);
    for (int i = 0; i < 24; i++) begin
      pulse(2'b11);
      if (s_oe) seen = 1'b1;
    end
    chk(!seen, "R10 unknown opcode drove lines", seen, 0);
    deselect("R10 deselect");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  op;
    logic [23:0] a;
    int k;
    void'($urandom(32'd7211));
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R11 reset state
    chk(dq_oe == 1'b0, "R11 oe after reset", dq_oe, 0);
    // R11 R4: default dummy of 8 used without any write
    do_read(8'h0B, 24'h000010, 2, 0, "R11 R4 default dummy read");
    // R1 R2: other codes, same behaviour
    do_read(8'h3B, 24'h000040, 2, 0, "R1 R2 code 3B");
    do_read(8'hBB, 24'h000040, 2, 0, "R1 R2 code BB");
    // R3: A23 and upper bits ignored
    do_read(8'h0B, 24'hC3A520, 1, 0, "R3 high address bits ignored");
    // R5: wrap at end of array
    do_read(8'h0B, 24'h0000FE, 4, 0, "R5 burst wraps array");
    // R4: dummy 0 and 15
    set_dummy(0);
    do_read(8'h0B, 24'h000077, 2, 0, "R4 zero dummy");
    set_dummy(15);
    do_read(8'hBB, 24'h000003, 2, 0, "R4 fifteen dummy");
    // R6 R7: OTP wrap, fixed dummy despite config 15
    do_read(8'h4B, 24'h00013E, 4, 0, "R6 R7 OTP wrap");
    set_dummy(3);
    do_read(8'h4B, 24'h000005, 1, 0, "R7 OTP dummy fixed");
    // R10 unknown opcode
    bad_op(8'h03);
    // R9 abort mid address, then clean read
    send_head(8'h0B, 24'hABCDEF, 5);
    deselect("R9 abort in address");
    do_read(8'h0B, 24'h000021, 1, 0, "R9 read after abort");
    // R9 R8 abort mid byte
    do_read(8'h3B, 24'h000090, 1, 2, "R9 mid byte abort");
    do_read(8'h4B, 24'h000011, 1, 0, "R9 R6 read after mid byte abort");
    // random mix
    for (int n = 0; n < 24; n++) begin
      k = int'($urandom % 6);
      a = 24'($urandom);
      if (k == 5) set_dummy(int'($urandom % 16));
      case (k)
        0: op = 8'h0B;
        1: op = 8'h3B;
        2: op = 8'hBB;
        3: op = 8'h4B;
        default: op = 8'h0B;
      endcase
      if (k == 4) begin
        op = 8'($urandom);
        while (op == 8'h0B || op == 8'h3B || op == 8'hBB || op == 8'h4B) op = 8'($urandom);
        bad_op(op);
      end else begin
        do_read(op, a, 1 + int'($urandom % 4), 0, "R2 R3 R5 R6 random read");
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule